// File: doc/BRIEF.md
# Pin and Pin-Pair Wait Unit

This block holds a small processor core in a stall while a wait instruction is in progress. It releases the core when the selected condition is met. There are three kinds of condition. The first counts a fixed number of clock cycles. The second waits for an edge on one pin chosen from a synchronized pin vector. The third checks a pair of adjacent pins, such as a differential pair, where the lower-numbered pin is the main pin of the pair.

A wait begins when the core pulses `start` together with a 5-bit sub-opcode, a 9-bit operand and a 4-bit pair-mode field. The operand is either a pin index or a cycle count. From the next cycle on, `stall` is high. When the condition is met, `stall` falls and `done` pulses for one cycle. Edges count only if they happen after the wait began: the pin state present at the start strobe becomes the reference. Level conditions on a pair can finish on the first cycle of the wait.

Top module: `pinWaitUnit`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `stall` and `done` are both low.
- R2: Sub-opcode 00000 with operand N ≥ 1 keeps `stall` high for exactly N cycles, starting the cycle after `start`.
- R3: For sub-opcode 00000, an operand of 0 behaves like an operand of 1 (one stall cycle).
- R4: Sub-opcodes 00001, 00010 and 00011 wait for any edge, a rising edge and a falling edge respectively. The pin is the one numbered by the operand's low bits. Only a change after the pin state sampled at `start` counts, so a level already present at `start` does not finish the wait, and an edge in the wrong direction does not either.
- R5: Sub-opcode 00110 waits for either pin of the pair to change. The pair is the operand with bit 0 cleared (the main pin) and that value plus one. Changes on pins outside the pair have no effect.
- R6: Sub-opcode 00111 with mode 0 waits for a rise of the main pin, and with mode 1 for a fall of the main pin. Changes on the partner pin are ignored.
- R7: Sub-opcode 00111 with mode 2 finishes when both pins of the pair are low, and with mode 3 when both are high. If the condition already holds, `stall` stays high for one cycle.
- R8: Sub-opcode 00111 with a mode above 3 finishes after one stall cycle. So does any sub-opcode not listed above.
- R9: `done` is high for exactly one cycle, `stall` is low in that cycle, and `stall` only falls together with `done`.
- R10: A `start` that arrives while `stall` is high is ignored, and the wait in progress keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a wait instruction (accepted only when idle) |
| subOp | input | 5 | Wait sub-opcode |
| operand | input | 9 | Pin index or clock count |
| pairMode | input | 4 | Condition select for sub-opcode 00111 |
| pins | input | NPINS (64) | Synchronized pin levels |
| stall | output | 1 | Core is held while high |
| done | output | 1 | One-cycle pulse when the wait finishes |

## Verification
Some internal faults are visible at the ports. If the reference sample latched at `start` is corrupt, the wait finishes without a real edge, or never finishes. If the pair base is mis-selected, the wait responds to the wrong pins or ignores the right ones. If the counter is off, the stall length is wrong. Each of these shows up as a `stall`/`done` mismatch in the same cycle the wrong pin change is sampled, or, for counts, in the first cycle past the expected length. A control state that fails to return to idle shows up as `stall` held high beyond its expected release.

// File: rtl/pinwait_pkg.sv
package pinwait_pkg;
  localparam logic [4:0] SUB_CLOCKS  = 5'b00000;
  localparam logic [4:0] SUB_ANYEDGE = 5'b00001;
  localparam logic [4:0] SUB_RISE    = 5'b00010;
  localparam logic [4:0] SUB_FALL    = 5'b00011;
  localparam logic [4:0] SUB_PAIRCHG = 5'b00110;
  localparam logic [4:0] SUB_PAIRSEL = 5'b00111;

  localparam logic [3:0] PMODE_RISE  = 4'd0;
  localparam logic [3:0] PMODE_FALL  = 4'd1;
  localparam logic [3:0] PMODE_LOW   = 4'd2;
  localparam logic [3:0] PMODE_HIGH  = 4'd3;

  typedef struct packed {
    logic load;    // accept a new instruction
    logic step;    // one busy cycle elapses
    logic finish;  // condition met this cycle
  } waitStrobes_t;

  typedef enum logic {ST_IDLE, ST_BUSY} waitState_t;
endpackage

// File: rtl/pinWaitDatapath.sv
module pinWaitDatapath
  import pinwait_pkg::*;
#(
  parameter int NPINS = 64,
  parameter int OPW   = 9,
  parameter int SUBW  = 5,
  parameter int MODEW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  waitStrobes_t       strb,
  input  logic [SUBW-1:0]    subOpIn,
  input  logic [OPW-1:0]     operandIn,
  input  logic [MODEW-1:0]   pairModeIn,
  input  logic [NPINS-1:0]   pins,
  output logic               hit
);
  localparam int IDXW   = $clog2(NPINS);
  localparam int NPAIRS = NPINS / 2;
  localparam int PIDXW  = IDXW - 1;

  // Split the pin vector into adjacent pairs: bit 0 is the main (lower) pin.
  logic [1:0] pairVec [NPAIRS];
  for (genvar g = 0; g < NPAIRS; g++) begin : gPair
    assign pairVec[g] = {pins[2*g+1], pins[2*g]};
  end

  logic [SUBW-1:0]  subOpR;
  logic [MODEW-1:0] modeR;
  logic [IDXW-1:0]  idxR;
  logic [OPW-1:0]   countR;
  logic             prevPin;
  logic [1:0]       prevPair;

  logic [IDXW-1:0]  loadIdx;
  logic             loadPin;
  logic [1:0]       loadPair;
  logic             curPin;
  logic [1:0]       curPair;

  assign loadIdx  = operandIn[IDXW-1:0];
  assign loadPin  = pins[loadIdx];
  assign loadPair = pairVec[loadIdx[IDXW-1:1]];
  assign curPin   = pins[idxR];
  assign curPair  = pairVec[idxR[IDXW-1:1]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subOpR   <= '0;
      modeR    <= '0;
      idxR     <= '0;
      countR   <= '0;
      prevPin  <= 1'b0;
      prevPair <= 2'b00;
    end else if (strb.load) begin
      subOpR   <= subOpIn;
      modeR    <= pairModeIn;
      idxR     <= loadIdx;
      countR   <= (operandIn == '0) ? OPW'(1) : operandIn;
      prevPin  <= loadPin;
      prevPair <= loadPair;
    end else if (strb.step) begin
      if (countR != '0) countR <= countR - OPW'(1);
      prevPin  <= curPin;
      prevPair <= curPair;
    end
  end

  logic pairRiseMain, pairFallMain;
  assign pairRiseMain = !prevPair[0] && curPair[0];
  assign pairFallMain = prevPair[0] && !curPair[0];

  always_comb begin
    unique case (subOpR)
      SUB_CLOCKS:  hit = (countR == OPW'(1));
      SUB_ANYEDGE: hit = (curPin != prevPin);
      SUB_RISE:    hit = !prevPin && curPin;
      SUB_FALL:    hit = prevPin && !curPin;
      SUB_PAIRCHG: hit = (curPair != prevPair);
      SUB_PAIRSEL: begin
        unique case (modeR)
          PMODE_RISE: hit = pairRiseMain;
          PMODE_FALL: hit = pairFallMain;
          PMODE_LOW:  hit = (curPair == 2'b00);
          PMODE_HIGH: hit = (curPair == 2'b11);
          default:    hit = 1'b1;
        endcase
      end
      default:     hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/pinWaitControl.sv
module pinWaitControl
  import pinwait_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         hit,
  output waitStrobes_t strb,
  output logic         stall,
  output logic         done
);
  waitState_t state;

  assign strb.load   = start && (state == ST_IDLE);
  assign strb.step   = (state == ST_BUSY);
  assign strb.finish = (state == ST_BUSY) && hit;
  assign stall       = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.load)        state <= ST_BUSY;
      else if (strb.finish) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/pinWaitUnit.sv
module pinWaitUnit
  import pinwait_pkg::*;
#(
  parameter int NPINS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [4:0]       subOp,
  input  logic [8:0]       operand,
  input  logic [3:0]       pairMode,
  input  logic [NPINS-1:0] pins,
  output logic             stall,
  output logic             done
);
  waitStrobes_t strb;
  logic         hit;

  pinWaitControl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .hit   (hit),
    .strb  (strb),
    .stall (stall),
    .done  (done)
  );

  pinWaitDatapath #(.NPINS(NPINS), .OPW(9), .SUBW(5), .MODEW(4)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .subOpIn    (subOp),
    .operandIn  (operand),
    .pairModeIn (pairMode),
    .pins       (pins),
    .hit        (hit)
  );
endmodule

// File: rtl/pinWaitChecker.sv
module pinWaitChecker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic stall,
  input logic done
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!stall && !done));

  assert_start_stalls_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !stall) |=> stall);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_unstalled_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !stall);

  assert_release_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> done);

  assert_done_after_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(stall));
endmodule

bind pinWaitUnit pinWaitChecker uChk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .stall (stall),
  .done  (done)
);

// File: tb/tb_pinWaitUnit.sv
`timescale 1ns/1ps
module tb_pinWaitUnit;
  localparam int NPINS = 64;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [4:0]       subOp = '0;
  logic [8:0]       operand = '0;
  logic [3:0]       pairMode = '0;
  logic [NPINS-1:0] pins = '0;
  logic             stall, done;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  pinWaitUnit #(.NPINS(NPINS)) dut (
    .clk(clk), .rstN(rstN), .start(start), .subOp(subOp),
    .operand(operand), .pairMode(pairMode), .pins(pins),
    .stall(stall), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual stall/done=%b expected=%b at %0t",
               tag, what, act, exp, $time);
    end
  endtask

  // At a negedge: expect stall high, then advance one cycle.
  task automatic stepStalled(input string tag);
    check(stall === 1'b1 && done === 1'b0, tag, "still waiting",
          {stall, done}, 2'b10);
    @(negedge clk);
  endtask

  // At a negedge: expect the done pulse, then its single-cycle end.
  task automatic expectDone(input string tag);
    check(stall === 1'b0 && done === 1'b1, tag, "done pulse",
          {stall, done}, 2'b01);
    @(negedge clk);
    check(done === 1'b0 && stall === 1'b0, tag, "done one cycle",
          {stall, done}, 2'b00);
  endtask

  task automatic issue(input logic [4:0] op, input logic [8:0] arg,
                       input logic [3:0] mode);
    @(negedge clk);
    subOp = op; operand = arg; pairMode = mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic testReset();
    check(stall === 1'b0 && done === 1'b0, "R1", "in reset", {stall, done}, 2'b00);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(stall === 1'b0 && done === 1'b0, "R1", "after reset", {stall, done}, 2'b00);
  endtask

  task automatic testClocks(input logic [8:0] n, input string tag);
    int len = (n == 0) ? 1 : int'(n);
    issue(5'b00000, n, 4'd0);
    for (int i = 0; i < len; i++) stepStalled(tag);
    expectDone(tag);
  endtask

  task automatic testSinglePin();
    // any edge on pin 5
    issue(5'b00001, 9'd5, 4'd0);
    stepStalled("R4");
    pins[5] = ~pins[5];
    stepStalled("R4");
    expectDone("R4");
    // rise on pin 9 with the pin already high: level does not count
    pins[9] = 1'b1;
    issue(5'b00010, 9'd9, 4'd0);
    stepStalled("R4");
    pins[9] = 1'b0;              // falling edge, wrong direction
    stepStalled("R4");
    stepStalled("R4");
    pins[9] = 1'b1;
    stepStalled("R4");
    expectDone("R4");
    // fall on pin 12, rising first is ignored
    pins[12] = 1'b0;
    issue(5'b00011, 9'd12, 4'd0);
    pins[12] = 1'b1;
    stepStalled("R4");
    stepStalled("R4");
    pins[12] = 1'b0;
    stepStalled("R4");
    expectDone("R4");
  endtask

  task automatic testPairChange();
    // operand 7 selects pair 6/7; pin 8 lies outside
    issue(5'b00110, 9'd7, 4'd0);
    pins[8] = ~pins[8];
    stepStalled("R5");
    stepStalled("R5");
    pins[7] = ~pins[7];
    stepStalled("R5");
    expectDone("R5");
  endtask

  task automatic testPairEdges();
    // rise on main pin of pair 10/11 (operand 11), partner ignored
    pins[11:10] = 2'b00;
    issue(5'b00111, 9'd11, 4'd0);
    pins[11] = 1'b1;
    stepStalled("R6");
    stepStalled("R6");
    pins[10] = 1'b1;
    stepStalled("R6");
    expectDone("R6");
    // fall on main pin of pair 14/15
    pins[15:14] = 2'b01;
    issue(5'b00111, 9'd14, 4'd1);
    pins[15] = 1'b0;
    stepStalled("R6");
    stepStalled("R6");
    pins[14] = 1'b0;
    stepStalled("R6");
    expectDone("R6");
  endtask

  task automatic testPairLevels();
    // both low already true: one stall cycle
    pins[17:16] = 2'b00;
    issue(5'b00111, 9'd16, 4'd2);
    stepStalled("R7");
    expectDone("R7");
    // both high reached in two steps on pair 20/21
    pins[21:20] = 2'b00;
    issue(5'b00111, 9'd21, 4'd3);
    pins[20] = 1'b1;
    stepStalled("R7");
    stepStalled("R7");
    pins[21] = 1'b1;
    stepStalled("R7");
    expectDone("R7");
  endtask

  task automatic testUndefined();
    issue(5'b00111, 9'd2, 4'd9);
    stepStalled("R8");
    expectDone("R8");
    issue(5'b00100, 9'd100, 4'd0);
    stepStalled("R8");
    expectDone("R8");
  endtask

  task automatic testIgnoreStart();
    issue(5'b00000, 9'd5, 4'd0);
    stepStalled("R10");
    subOp = 5'b00000; operand = 9'd1; start = 1'b1;
    stepStalled("R10");
    start = 1'b0;
    for (int i = 0; i < 3; i++) stepStalled("R10");
    expectDone("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testClocks(9'd4, "R2");
    testClocks(9'd1, "R2");
    testClocks(9'd0, "R3");
    testSinglePin();
    testPairChange();
    testPairEdges();
    testPairLevels();
    testUndefined();
    testIgnoreStart();
    testClocks(9'd300, "R2");
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule